// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block is a bus slave that serves one or more alias windows, each 32 MB wide. Every 32-bit word in a window stands for one bit of a 1 MB region of real memory. A read of an alias word fetches the memory that holds the bit and returns that bit alone. A write to an alias word runs a read-modify-write on the memory. The write changes exactly the addressed bit, copies its value from bit 0 of the write data, and returns every other bit of the fetched data unchanged.

The slave side takes one request at a time over a valid/ready handshake and returns a response over a second valid/ready handshake. The master side issues size-aligned requests of 1, 2 or 4 bytes to memory. For a read-modify-write, the master side holds a lock line from the read through the completion of the write-back, so no other master can use the memory in between. Memory data on the master side is right-justified: byte k of the access travels in data bits [8k+7:8k]. A memory error on either phase ends the access with an error response. A missing window, an illegal size or a disabled bridge also returns an error, and none of these reaches memory.

Top module: `bitband_bridge`

## Requirements
- R1: An access whose address bits [31:25] match a window's alias base targets memory address `source_base | (addr[24:0] >> 5)`. The default windows are alias 0x2200_0000 to source 0x2000_0000, and alias 0x4200_0000 to source 0x4000_0000.
- R2: Size code 0, 1 or 2 selects 1, 2 or 4 bytes. The memory address is rounded down to a multiple of that byte count, and the memory request carries the same size code.
- R3: The selected bit index is `addr[6:2] & (8*bytes - 1)`. It picks that bit of the right-justified memory data.
- R4: A read issues one memory read and answers with the selected bit in response bit 0, all other bits zero, and error low.
- R5: A write issues one memory read and then one memory write to the same address and size. The written data equals the fetched data with only the selected bit replaced by write-data bit 0. Bits above the access width are zero.
- R6: During a write, the lock output is high on both memory requests and stays high between them. During a read, the lock output is low.
- R7: A memory read error ends the access with an error response, and no write-back is issued.
- R8: An error on the write-back is returned as the error response of the alias write.
- R9: An address outside every window, or size code 3, gets an error response and causes no memory request.
- R10: With the enable parameter at 0, every access gets an error response and no memory request is ever made.
- R11: After reset the slave is ready and no response is pending. Once a request is accepted, ready stays low until the response is taken, and the response holds steady until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Alias request valid |
| s_ready | output | 1 | Bridge can accept a request |
| s_addr | input | 32 | Alias byte address |
| s_size | input | 2 | Size code: 0=1, 1=2, 2=4 bytes |
| s_we | input | 1 | 1 = write, 0 = read |
| s_wdata | input | 32 | Write data, only bit 0 used |
| s_rvalid | output | 1 | Response valid |
| s_rready | input | 1 | Response accepted |
| s_rdata | output | 32 | Read bit in bit 0 |
| s_rerr | output | 1 | Response carries an error |
| m_valid | output | 1 | Memory request valid |
| m_ready | input | 1 | Memory accepts request |
| m_addr | output | 32 | Aligned memory byte address |
| m_size | output | 2 | Memory size code |
| m_we | output | 1 | Memory write |
| m_wdata | output | 32 | Right-justified write data |
| m_lock | output | 1 | Locked read-modify-write in progress |
| m_rvalid | input | 1 | Memory response, at least one cycle after acceptance |
| m_rdata | input | 32 | Right-justified read data |
| m_rerr | input | 1 | Memory response error |

## Verification
The hardest case to reach is an error that arrives mid-sequence: a failed read inside a read-modify-write must stop the write-back, and a failed write-back must still come back as the response while memory stays unchanged. The bench memory model has per-phase error switches that the stimulus arms for one transaction. The bench then compares its request counters and memory contents before and after that transaction. Random memory ready and latency stretch the locked window and the response hold. Randomly delayed response acceptance exercises the single-outstanding rule.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BIDX_W = $clog2(DATA_W);

    typedef logic [1:0] bb_size_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_RESP = 2'd3
    } bb_state_e;

    typedef struct packed {
        bb_state_e          state;
        logic               issued;
        logic               is_wr;
        logic               wbit;
        bb_size_t           size;
        logic [BIDX_W-1:0]  bidx;
        logic [ADDR_W-1:0]  maddr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic               err;
    } bb_ctx_t;

endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode
    import bb_pkg::*;
#(
    parameter int                          NUM_WIN     = 2,
    parameter int                          WIN_BITS    = 25,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASES = '0,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] SRC_BASES   = '0,
    parameter bit                          ENABLE      = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  bb_size_t          size,
    output logic              hit,
    output logic              legal,
    output logic [ADDR_W-1:0] tgt,
    output logic [BIDX_W-1:0] bidx
);

    localparam int BYTE_SHIFT = BIDX_W;   // word->bit (2) plus bit->byte (3)

    logic [NUM_WIN-1:0]             match;
    logic [NUM_WIN-1:0][ADDR_W-1:0] cand;
    logic [ADDR_W-1:0]              raw;
    logic                           unused_lsb;

    assign unused_lsb = ^addr[1:0];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign match[g] = ENABLE &&
                          (addr[ADDR_W-1:WIN_BITS] == ALIAS_BASES[g][ADDR_W-1:WIN_BITS]);
        assign cand[g]  = match[g]
                        ? (SRC_BASES[g] | (ADDR_W'(addr[WIN_BITS-1:0]) >> BYTE_SHIFT))
                        : '0;
    end

    always_comb begin
        raw = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            raw = raw | cand[i];
        end
        hit   = |match;
        legal = (size != 2'd3);
        tgt   = raw & ~((ADDR_W'(1) << size) - ADDR_W'(1));
        case (size)
            2'd0:    bidx = {2'b00, addr[4:2]};
            2'd1:    bidx = {1'b0, addr[5:2]};
            default: bidx = addr[6:2];
        endcase
    end

endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane
    import bb_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  bb_size_t          size,
    input  logic [BIDX_W-1:0] bidx,
    input  logic              wbit,
    output logic              bit_out,
    output logic [DATA_W-1:0] merged
);

    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] sel;

    always_comb begin
        if (size >= 2'd2) begin
            keep = '1;
        end else begin
            keep = (DATA_W'(1) << (6'd8 << size)) - DATA_W'(1);
        end
        sel     = DATA_W'(1) << bidx;
        bit_out = |(data & sel);
        if (wbit) begin
            merged = (data & keep) | sel;
        end else begin
            merged = data & keep & ~sel;
        end
    end

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int                             NUM_WIN     = 2,
    parameter int                             WIN_BITS    = 25,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] SRC_BASES   = {32'h4000_0000, 32'h2000_0000},
    parameter bit                             ENABLE      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [1:0]        s_size,
    input  logic              s_we,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic              s_rerr,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [ADDR_W-1:0] m_addr,
    output logic [1:0]        m_size,
    output logic              m_we,
    output logic [DATA_W-1:0] m_wdata,
    output logic              m_lock,
    input  logic              m_rvalid,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_rerr
);

    localparam bb_ctx_t CTX_RST = '{state: ST_IDLE, size: 2'd0, default: '0};

    bb_ctx_t ctx_q, ctx_d;

    logic              dec_hit, dec_legal;
    logic [ADDR_W-1:0] dec_tgt;
    logic [BIDX_W-1:0] dec_bidx;
    logic              lane_bit;
    logic [DATA_W-1:0] lane_merged;
    logic              unused_wdata;

    assign unused_wdata = ^s_wdata[DATA_W-1:1];

    bb_window_decode #(
        .NUM_WIN    (NUM_WIN),
        .WIN_BITS   (WIN_BITS),
        .ALIAS_BASES(ALIAS_BASES),
        .SRC_BASES  (SRC_BASES),
        .ENABLE     (ENABLE)
    ) i_decode (
        .addr (s_addr),
        .size (s_size),
        .hit  (dec_hit),
        .legal(dec_legal),
        .tgt  (dec_tgt),
        .bidx (dec_bidx)
    );

    bb_bit_lane i_lane (
        .data   (m_rdata),
        .size   (ctx_q.size),
        .bidx   (ctx_q.bidx),
        .wbit   (ctx_q.wbit),
        .bit_out(lane_bit),
        .merged (lane_merged)
    );

    // Port outputs from registered context
    assign s_ready  = (ctx_q.state == ST_IDLE);
    assign s_rvalid = (ctx_q.state == ST_RESP);
    assign s_rdata  = ctx_q.rdata;
    assign s_rerr   = ctx_q.err;
    assign m_valid  = ((ctx_q.state == ST_RD) || (ctx_q.state == ST_WR)) && !ctx_q.issued;
    assign m_we     = (ctx_q.state == ST_WR);
    assign m_addr   = ctx_q.maddr;
    assign m_size   = ctx_q.size;
    assign m_wdata  = ctx_q.wdata;
    assign m_lock   = ctx_q.is_wr && ((ctx_q.state == ST_RD) || (ctx_q.state == ST_WR));

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.state)
            ST_IDLE: begin
                if (s_valid) begin
                    ctx_d.is_wr  = s_we;
                    ctx_d.wbit   = s_wdata[0];
                    ctx_d.size   = s_size;
                    ctx_d.bidx   = dec_bidx;
                    ctx_d.maddr  = dec_tgt;
                    ctx_d.wdata  = '0;
                    ctx_d.rdata  = '0;
                    ctx_d.issued = 1'b0;
                    if (dec_hit && dec_legal) begin
                        ctx_d.err   = 1'b0;
                        ctx_d.state = ST_RD;
                    end else begin
                        ctx_d.err   = 1'b1;
                        ctx_d.state = ST_RESP;
                    end
                end
            end
            ST_RD: begin
                if (m_valid && m_ready) begin
                    ctx_d.issued = 1'b1;
                end
                if (ctx_q.issued && m_rvalid) begin
                    if (m_rerr) begin
                        ctx_d.err   = 1'b1;
                        ctx_d.state = ST_RESP;
                    end else if (!ctx_q.is_wr) begin
                        ctx_d.rdata = {{(DATA_W-1){1'b0}}, lane_bit};
                        ctx_d.state = ST_RESP;
                    end else begin
                        ctx_d.wdata  = lane_merged;
                        ctx_d.issued = 1'b0;
                        ctx_d.state  = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (m_valid && m_ready) begin
                    ctx_d.issued = 1'b1;
                end
                if (ctx_q.issued && m_rvalid) begin
                    ctx_d.err   = m_rerr;
                    ctx_d.state = ST_RESP;
                end
            end
            default: begin
                if (s_rready) begin
                    ctx_d.state = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= CTX_RST;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    // R11: response stays steady while it waits
    a_r11_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata) && $stable(s_rerr));

    // R11: no new request accepted while a response is pending
    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> !s_ready);

    // R6: every write-back is locked
    a_r6_wr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_we |-> m_lock);

    // R6: lock released only when the response appears
    a_r6_lock_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m_lock) |-> s_rvalid);

    // R4: good response carries only bit 0
    a_r4_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rerr |-> (s_rdata[DATA_W-1:1] == '0));

    // R2: memory address aligned to the access size
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> ((m_addr & ((ADDR_W'(1) << m_size) - ADDR_W'(1))) == '0));

    // R5: memory request held until accepted
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_we) && $stable(m_wdata));

endmodule

// File: tb/test_bitband_bridge.sv
module test_bitband_bridge;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_addr = '0;
    logic [1:0]  s_size = '0;
    logic        s_we = 1'b0;
    logic [31:0] s_wdata = '0;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic [31:0] s_rdata;
    logic        s_rerr;
    logic        m_valid;
    logic        m_ready;
    logic [31:0] m_addr;
    logic [1:0]  m_size;
    logic        m_we;
    logic [31:0] m_wdata;
    logic        m_lock;
    logic        m_rvalid;
    logic [31:0] m_rdata;
    logic        m_rerr;

    // disabled instance
    logic        o_s_ready, o_s_rvalid, o_s_rerr, o_m_valid, o_m_we, o_m_lock;
    logic [31:0] o_s_rdata, o_m_addr, o_m_wdata;
    logic [1:0]  o_m_size;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitband_bridge i_bitband_bridge (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_size(s_size),
        .s_we(s_we), .s_wdata(s_wdata), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .s_rdata(s_rdata), .s_rerr(s_rerr),
        .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_size(m_size),
        .m_we(m_we), .m_wdata(m_wdata), .m_lock(m_lock),
        .m_rvalid(m_rvalid), .m_rdata(m_rdata), .m_rerr(m_rerr)
    );

    bitband_bridge #(.ENABLE(1'b0)) i_bitband_bridge_off (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(o_s_ready), .s_addr(s_addr), .s_size(s_size),
        .s_we(s_we), .s_wdata(s_wdata), .s_rvalid(o_s_rvalid), .s_rready(1'b1),
        .s_rdata(o_s_rdata), .s_rerr(o_s_rerr),
        .m_valid(o_m_valid), .m_ready(1'b1), .m_addr(o_m_addr), .m_size(o_m_size),
        .m_we(o_m_we), .m_wdata(o_m_wdata), .m_lock(o_m_lock),
        .m_rvalid(1'b0), .m_rdata(32'h0), .m_rerr(1'b0)
    );

    int off_bad = 0;
    int off_resp = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (o_m_valid) off_bad++;
            if (o_s_rvalid) begin
                off_resp++;
                if (!o_s_rerr) off_bad++;
            end
        end
    end

    // ---------------- memory model ----------------
    logic [7:0] mem  [int unsigned];
    logic [7:0] refm [int unsigned];
    logic inject_rd_err = 1'b0;
    logic inject_wr_err = 1'b0;

    function automatic logic [7:0] init_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [7:0] mem_get(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : init_byte(a);
    endfunction

    function automatic logic [7:0] ref_get(input logic [31:0] a);
        return refm.exists(a) ? refm[a] : init_byte(a);
    endfunction

    int          n_rd = 0, n_wr = 0;
    logic [31:0] rd_addr_l, wr_addr_l, wr_data_l;
    logic [1:0]  rd_size_l, wr_size_l;
    logic        rd_lock_l, wr_lock_l;

    logic        pend;
    logic        p_we;
    logic [31:0] p_addr, p_data;
    logic [1:0]  p_size;
    int          p_lat;

    always @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            m_ready  <= 1'b0;
            m_rvalid <= 1'b0;
            m_rerr   <= 1'b0;
            m_rdata  <= '0;
        end else begin
            m_rvalid <= 1'b0;
            m_rerr   <= 1'b0;
            m_rdata  <= '0;
            m_ready  <= ($urandom_range(3) != 0);
            if (pend) begin
                if (p_lat == 0) begin
                    pend     <= 1'b0;
                    m_rvalid <= 1'b1;
                    if (p_we) begin
                        if (inject_wr_err) m_rerr <= 1'b1;
                        else for (int b = 0; b < (1 << p_size); b++) mem[p_addr + b] = p_data[8*b +: 8];
                    end else begin
                        if (inject_rd_err) m_rerr <= 1'b1;
                        else begin
                            logic [31:0] d;
                            d = '0;
                            for (int b = 0; b < (1 << p_size); b++) d[8*b +: 8] = mem_get(p_addr + b);
                            m_rdata <= d;
                        end
                    end
                end else begin
                    p_lat <= p_lat - 1;
                end
            end else if (m_valid && m_ready) begin
                pend   <= 1'b1;
                p_lat  <= $urandom_range(2);
                p_we   <= m_we;
                p_addr <= m_addr;
                p_size <= m_size;
                p_data <= m_wdata;
                if (m_we) begin
                    n_wr++; wr_addr_l <= m_addr; wr_size_l <= m_size;
                    wr_data_l <= m_wdata; wr_lock_l <= m_lock;
                end else begin
                    n_rd++; rd_addr_l <= m_addr; rd_size_l <= m_size; rd_lock_l <= m_lock;
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_tgt(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] base, t;
        base = (a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000;
        t = base | ({7'b0, a[24:0]} >> 5);
        return t & ~((32'd1 << sz) - 32'd1);
    endfunction

    function automatic logic [4:0] exp_idx(input logic [31:0] a, input logic [1:0] sz);
        return a[6:2] & 5'((8 << sz) - 1);
    endfunction

    task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic we,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er);
        int hold;
        logic bad;
        @(negedge clk);
        s_valid = 1'b1; s_addr = a; s_size = sz; s_we = we; s_wdata = wd;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        bad = 1'b0;
        while (!s_rvalid) begin
            if (s_ready) bad = 1'b1;
            @(negedge clk);
        end
        rd = s_rdata; er = s_rerr;
        hold = $urandom_range(2);
        repeat (hold) begin
            @(negedge clk);
            if (!s_rvalid || s_ready || s_rdata !== rd || s_rerr !== er) bad = 1'b1;
        end
        chk("R11 busy and response hold", 32'(bad), 32'h0);
        s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
    endtask

    task automatic run_txn(input logic [31:0] a, input logic [1:0] sz, input logic we,
                           input logic [31:0] wd);
        logic [31:0] t, rd, expw;
        logic [4:0]  idx;
        logic [7:0]  bt;
        logic        er;
        int rd0, wr0;
        t   = exp_tgt(a, sz);
        idx = exp_idx(a, sz);
        rd0 = n_rd; wr0 = n_wr;
        access(a, sz, we, wd, rd, er);
        chk("R1 R2 memory address", rd_addr_l, t);
        chk("R2 memory size", 32'(rd_size_l), 32'(sz));
        chk("R4 R5 no error", 32'(er), 32'h0);
        chk("R4 R5 read count", 32'(n_rd - rd0), 32'd1);
        if (!we) begin
            bt = ref_get(t + 32'(idx >> 3));
            chk("R3 R4 read bit", rd, {31'b0, bt[idx[2:0]]});
            chk("R4 write count", 32'(n_wr - wr0), 32'd0);
            chk("R6 read unlocked", 32'(rd_lock_l), 32'h0);
        end else begin
            bt = ref_get(t + 32'(idx >> 3));
            bt[idx[2:0]] = wd[0];
            refm[t + 32'(idx >> 3)] = bt;
            expw = '0;
            for (int b = 0; b < (1 << sz); b++) expw[8*b +: 8] = ref_get(t + b);
            chk("R5 write count", 32'(n_wr - wr0), 32'd1);
            chk("R5 write-back address", wr_addr_l, t);
            chk("R5 write-back data", wr_data_l, expw);
            chk("R6 rmw locked", {30'b0, rd_lock_l, wr_lock_l}, 32'h3);
            for (int b = 0; b < (1 << sz); b++)
                chk("R5 memory byte", 32'(mem_get(t + b)), 32'(ref_get(t + b)));
        end
    endtask

    task automatic run_err(input string req, input logic [31:0] a, input logic [1:0] sz,
                           input logic we, input int exp_rd, input int exp_wr);
        logic [31:0] rd, t;
        logic er;
        int rd0, wr0;
        rd0 = n_rd; wr0 = n_wr;
        t = exp_tgt(a, 2'd2);
        access(a, sz, we, 32'h1, rd, er);
        chk(req, 32'(er), 32'h1);
        chk(req, 32'(n_rd - rd0), 32'(exp_rd));
        chk(req, 32'(n_wr - wr0), 32'(exp_wr));
        for (int b = 0; b < 4; b++) chk(req, 32'(mem_get(t + b)), 32'(ref_get(t + b)));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        void'($urandom(32'd7411));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset ready", 32'(s_ready), 32'h1);
        chk("R11 reset no response", 32'(s_rvalid), 32'h0);
        chk("R6 reset no request", {30'b0, m_valid, m_lock}, 32'h0);

        // directed translation and size cases
        run_txn(32'h2200_0000, 2'd0, 1'b0, 32'h0);
        run_txn(32'h2200_1234 & ~32'h3, 2'd1, 1'b0, 32'h0);
        run_txn(32'h4200_0FFC, 2'd2, 1'b1, 32'h1);
        run_txn(32'h4200_0FFC, 2'd2, 1'b0, 32'h0);
        run_txn(32'h4200_0FFC, 2'd0, 1'b1, 32'hFFFF_FFFE);
        run_txn(32'h4200_0FFC, 2'd2, 1'b0, 32'h0);
        // top of window 0: target 0x200F_FFFC, bit 31
        run_txn(32'h23FF_FFFC, 2'd2, 1'b1, 32'h0);
        run_txn(32'h23FF_FFFC, 2'd0, 1'b0, 32'h0);
        run_txn(32'h23FF_FFFC, 2'd2, 1'b1, 32'h1);
        run_txn(32'h23FF_FFFC, 2'd1, 1'b0, 32'h0);

        // R9 decode and size errors
        run_err("R9 outside window", 32'h3200_0040, 2'd0, 1'b1, 0, 0);
        run_err("R9 size code 3", 32'h2200_0040, 2'd3, 1'b1, 0, 0);

        // R7 read error in rmw and plain read
        inject_rd_err = 1'b1;
        run_err("R7 rmw read error", 32'h2200_0080, 2'd2, 1'b1, 1, 0);
        run_err("R7 read error", 32'h2200_0080, 2'd2, 1'b0, 1, 0);
        inject_rd_err = 1'b0;

        // R8 write-back error
        inject_wr_err = 1'b1;
        run_err("R8 write-back error", 32'h4200_00A0, 2'd2, 1'b1, 1, 1);
        inject_wr_err = 1'b0;

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            logic [1:0]  sz;
            a  = ($urandom_range(1) != 0) ? 32'h4200_0000 : 32'h2200_0000;
            a  = a | ($urandom() & 32'h0000_1FFC);
            sz = 2'($urandom_range(2));
            run_txn(a, sz, 1'($urandom_range(1)), $urandom());
        end

        // R10 disabled instance
        chk("R10 disabled no memory or bad response", 32'(off_bad), 32'h0);
        chk("R10 disabled responded", 32'(off_resp > 0), 32'h1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule